// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master for a 12-bit sampling converter that talks over a three-wire serial link: an active-low select, a serial clock, and a data line driven by the converter. A request on `start` makes the block pull the select low and toggle the serial clock for one 16-clock frame. The block reads the conversion result from that frame and presents it on `sample` with a one-cycle `sample_vld` strobe. The serial clock is made by dividing the system clock by a parameter, and it rests high whenever the select is high.

Between frames the block holds the select high for a programmable quiet interval. A request that arrives while a frame or a quiet interval is running is held and served when the block returns to idle. A `pd_req` pulse asks for a power-down frame, in which the select is raised early so that the converter enters its low-power state. The converter produces one invalid result after reset and one after waking from power-down. The block discards that result without raising the strobe.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and just after it is released, `adc_cs_n` = 1, `adc_sclk` = 1, `busy` = 0, `sample_vld` = 0 and `sample` = 0.
- R2: A normal frame holds `adc_cs_n` low for exactly 32·DIV clocks and gives 16 falling edges of `adc_sclk`. The first falling edge comes DIV clocks after `adc_cs_n` falls, and each clock phase lasts DIV clocks. `adc_sclk` is high whenever `adc_cs_n` is high.
- R3: `adc_sdo` is sampled on the rising edges of `adc_sclk`. The bits read on rising edges 4 to 15 form `sample[11]` down to `sample[0]`, MSB first. The level on the line before that (frame bits 0 to 3) has no effect on `sample`.
- R4: `sample_vld` pulses for exactly one clock, in the cycle in which `adc_cs_n` rises at the end of a normal frame whose result is kept. `sample` changes only at that point and holds its value otherwise.
- R5: The first normal frame after reset updates neither `sample` nor `sample_vld`.
- R6: Between two frames, `adc_cs_n` stays high for at least QUIET_CYC+1 clocks.
- R7: A `start` pulse that arrives while a frame or a quiet interval is in progress is kept and starts one frame after the block returns to idle.
- R8: A `pd_req` pulse is kept, and it starts a power-down frame. In that frame `adc_cs_n` rises DIV clocks after the rising edge that follows falling edge PD_EDGE, so it is low for (2·PD_EDGE+1)·DIV clocks. A power-down frame never raises `sample_vld`.
- R9: The first normal frame after a power-down frame is discarded: `sample_vld` stays low and `sample` is unchanged.
- R10: When both kinds of request are waiting in idle, the power-down frame starts first and the held start follows.
- R11: `busy` is 1 while a frame or a quiet interval runs, or while a request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request for one conversion frame |
| pd_req | input | 1 | Request for a power-down frame |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| sample | output | 12 | Last kept conversion result |
| sample_vld | output | 1 | One-cycle strobe when `sample` is updated |
| busy | output | 1 | A frame, a quiet interval or a held request is present |

## Verification
A launch lowers `adc_cs_n` one clock after the request is registered, and the first falling edge of the serial clock follows DIV clocks later. The result and its strobe appear in the same cycle that `adc_cs_n` rises, which is 32·DIV clocks after it fell for a normal frame and (2·PD_EDGE+1)·DIV clocks for a power-down frame. The bench measures these intervals by counting system clocks at every falling clock edge, between the select and clock transitions it observes. It compares the strobe and `sample` only in the cycle in which the select rises, and it counts any strobe in any other cycle as a failure.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV         = 5,
  parameter int QUIET_CYC   = 8,
  parameter int PD_EDGE     = 5,
  parameter int SAMPLE_W    = 12,
  parameter int FRAME_SCLKS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                pd_req,
  input  logic                adc_sdo,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_vld,
  output logic                busy
);
  localparam int LEAD = FRAME_SCLKS - SAMPLE_W;
  localparam int DW   = $clog2(DIV + 1);
  localparam int PW   = $clog2(2 * FRAME_SCLKS + 1);
  localparam int QW   = $clog2(QUIET_CYC + 1);
  localparam int HW   = $clog2(QUIET_CYC + 2);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [PW-1:0] PH_END   = PW'(2 * FRAME_SCLKS - 1);
  localparam logic [PW-1:0] PH_PD    = PW'(2 * PD_EDGE);
  localparam logic [PW-1:0] PH_CAP   = PW'(2 * LEAD - 1);
  localparam logic [QW-1:0] Q_LAST   = QW'(QUIET_CYC - 1);
  localparam logic [HW-1:0] HI_SAT   = HW'(QUIET_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_QUIET} state_t;

  state_t              st;
  logic [DW-1:0]       div_cnt;
  logic [PW-1:0]       ph;
  logic [QW-1:0]       q_cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic                start_pend, pd_pend, pd_frame, stale;

  wire tick = (div_cnt == DIV_LAST);

  assign busy = (st != S_IDLE) | start_pend | pd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div_cnt <= '0;
      ph <= '0;
      q_cnt <= '0;
      shreg <= '0;
      start_pend <= 1'b0;
      pd_pend <= 1'b0;
      pd_frame <= 1'b0;
      stale <= 1'b1;
      adc_cs_n <= 1'b1;
      adc_sclk <= 1'b1;
      sample <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= 1'b0;
      if (start)  start_pend <= 1'b1;
      if (pd_req) pd_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (pd_pend || pd_req || start_pend || start) begin
            st <= S_FRAME;
            adc_cs_n <= 1'b0;
            div_cnt <= '0;
            ph <= '0;
            pd_frame <= pd_pend | pd_req;
            if (pd_pend || pd_req) pd_pend <= 1'b0;
            else start_pend <= 1'b0;
          end
        end
        S_FRAME: begin
          if (!tick) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (pd_frame && ph == PH_PD) begin
              adc_cs_n <= 1'b1;
              st <= S_QUIET;
              q_cnt <= '0;
              stale <= 1'b1;
            end else if (ph == PH_END) begin
              adc_cs_n <= 1'b1;
              adc_sclk <= 1'b1;
              st <= S_QUIET;
              q_cnt <= '0;
              stale <= 1'b0;
              if (!stale) begin
                sample <= shreg;
                sample_vld <= 1'b1;
              end
            end else begin
              ph <= ph + 1'b1;
              adc_sclk <= ph[0];
              if (ph[0] && ph >= PH_CAP)
                shreg <= {shreg[SAMPLE_W-2:0], adc_sdo};
            end
          end
        end
        default: begin
          if (q_cnt == Q_LAST) st <= S_IDLE;
          else q_cnt <= q_cnt + 1'b1;
        end
      endcase
    end
  end

  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= HI_SAT;
    else if (!adc_cs_n) hi_run <= '0;
    else if (hi_run != HI_SAT) hi_run <= hi_run + 1'b1;
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk); // R2
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> !adc_cs_n); // R2
  AST_VLD_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $rose(adc_cs_n)); // R4
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> hi_run == HI_SAT); // R6
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R7
endmodule

// File: tb/test_adc_frame_reader.sv
`timescale 1ns/1ps
module test_adc_frame_reader;
  localparam int DIV = 5;
  localparam int QUIET = 8;
  localparam int PD = 5;

  logic clk = 0, rst_n = 0, start = 0, pd_req = 0;
  logic adc_cs_n, adc_sclk, sample_vld, busy;
  logic [11:0] sample;
  logic drv_en = 0, drv_bit = 0, lead_junk = 0;
  logic [11:0] adc_val = '0, fval = '0;
  int nfall = 0;
  wire adc_sdo = drv_en ? drv_bit : 1'bz;

  int checks = 0, errors = 0;
  int n_norm = 0, n_pd = 0, n_vld = 0;
  logic [5:0] hist = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.DIV(DIV), .QUIET_CYC(QUIET), .PD_EDGE(PD)) i_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .pd_req(pd_req), .adc_sdo(adc_sdo),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .sample(sample),
    .sample_vld(sample_vld), .busy(busy));

  function automatic int normal_len();
    return 32 * DIV;
  endfunction
  function automatic int pd_len();
    return (2 * PD + 1) * DIV;
  endfunction
  function automatic logic frame_bit(input logic [11:0] v, input int k, input logic junk);
    return (k < 4) ? junk : v[15 - k];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model
  always @(negedge adc_cs_n or posedge adc_cs_n or negedge adc_sclk) begin
    if (adc_cs_n) drv_en = 0;
    else if (adc_sclk) begin
      fval = adc_val; nfall = 0; drv_en = 1; drv_bit = frame_bit(fval, 0, lead_junk);
    end else begin
      nfall++;
      if (nfall >= 16) drv_en = 0;
      else drv_bit = frame_bit(fval, nfall, lead_junk);
    end
  end

  // monitor
  int low_cnt = 0, hi_cnt = 1000, falls = 0;
  logic pcs = 1, psclk = 1, exp_stale = 1, exp_v;
  always @(negedge clk) if (rst_n) begin
    if (!adc_cs_n) begin
      if (pcs) begin
        check(hi_cnt >= QUIET + 1, "R6 quiet gap", hi_cnt, QUIET + 1);
        low_cnt = 0; falls = 0;
      end
      low_cnt++;
      if (psclk && !adc_sclk) begin
        falls++;
        if (falls == 1) check(low_cnt == DIV + 1, "R2 select to first fall", low_cnt, DIV + 1);
      end
      if (sample_vld) check(0, "R4 strobe inside frame", 1, 0);
    end else begin
      if (!pcs) begin
        if (falls == 16) begin
          check(low_cnt == normal_len(), "R2 frame length", low_cnt, normal_len());
          n_norm++;
          exp_v = !exp_stale; exp_stale = 0;
          check(sample_vld == exp_v, "R4 R5 R9 strobe", int'(sample_vld), int'(exp_v));
          if (exp_v) begin
            check(sample == fval, "R3 sample value", int'(sample), int'(fval));
            n_vld++;
          end
          hist = {hist[3:0], 2'd1};
        end else begin
          check(falls == PD, "R8 falls before raise", falls, PD);
          check(low_cnt == pd_len(), "R8 power-down length", low_cnt, pd_len());
          check(!sample_vld, "R8 no strobe", int'(sample_vld), 0);
          exp_stale = 1; n_pd++;
          hist = {hist[3:0], 2'd2};
        end
        hi_cnt = 0;
      end else if (sample_vld) check(0, "R4 stray strobe", 1, 0);
      check(adc_sclk, "R2 clock parked", int'(adc_sclk), 1);
      hi_cnt++;
    end
    pcs = adc_cs_n; psclk = adc_sclk;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask
  task automatic pulse_pd();
    @(negedge clk) pd_req = 1;
    @(negedge clk) pd_req = 0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int nv, nn, np;
    logic [11:0] keep;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(adc_cs_n && adc_sclk && !busy && !sample_vld && sample == 0, "R1 reset state",
          int'({adc_cs_n, adc_sclk, busy, sample_vld}), 'b1100);
    rst_n = 1;
    repeat (20) @(negedge clk);
    check(adc_cs_n && !busy && sample == 0, "R1 after release", int'(sample), 0);

    // R5 first frame discarded
    adc_val = 12'h5A3;
    pulse_start();
    check(busy, "R11 busy in frame", int'(busy), 1);
    wait_idle();
    check(n_norm == 1 && n_vld == 0, "R5 first result dropped", n_vld, 0);
    check(sample == 0, "R5 sample unchanged", int'(sample), 0);

    // R4 valid sample held
    adc_val = 12'hA5C;
    pulse_start(); wait_idle();
    repeat (30) @(negedge clk);
    check(n_vld == 1 && sample == 12'hA5C, "R4 sample held", int'(sample), 'hA5C);

    // R7 start while busy
    nn = n_norm; nv = n_vld;
    adc_val = 12'h123;
    pulse_start();
    repeat (30) @(negedge clk);
    check(busy, "R11 busy mid frame", int'(busy), 1);
    adc_val = 12'hFFF;
    pulse_start();
    wait_idle();
    check(n_norm == nn + 2 && n_vld == nv + 2, "R7 held start served", n_norm - nn, 2);
    check(sample == 12'hFFF, "R3 all ones", int'(sample), 'hFFF);

    // R3 leading bits ignored, boundary zero
    lead_junk = 1; adc_val = 12'h000;
    pulse_start(); wait_idle();
    check(sample == 12'h000, "R3 leading ones ignored", int'(sample), 0);
    adc_val = 12'h801;
    pulse_start(); wait_idle();
    check(sample == 12'h801, "R3 edge bits", int'(sample), 'h801);
    lead_junk = 0;

    // R8 power-down, R9 wake discard
    nn = n_norm; nv = n_vld; np = n_pd; keep = sample;
    pulse_pd(); wait_idle();
    check(n_pd == np + 1 && n_vld == nv, "R8 power-down frame", n_pd - np, 1);
    check(sample == keep, "R8 sample kept", int'(sample), int'(keep));
    adc_val = 12'h777;
    pulse_start(); wait_idle();
    check(n_norm == nn + 1 && n_vld == nv, "R9 wake result dropped", n_vld - nv, 0);
    check(sample == keep, "R9 sample unchanged", int'(sample), int'(keep));
    adc_val = 12'h3C6;
    pulse_start(); wait_idle();
    check(n_vld == nv + 1 && sample == 12'h3C6, "R9 next result kept", int'(sample), 'h3C6);

    // R10 power-down ahead of start
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1; pd_req = 1;
    @(negedge clk) begin start = 0; pd_req = 0; end
    wait_idle();
    check(hist == 6'b01_10_01, "R10 order normal, power-down, normal", int'(hist), 'b011001);

    // random traffic
    for (int i = 0; i < 250; i++) begin
      adc_val = 12'($urandom);
      if ($urandom % 8 == 0) pulse_pd(); else pulse_start();
      repeat ($urandom % 200) @(negedge clk);
    end
    wait_idle();
    check(!busy && adc_cs_n, "R11 idle at end", int'(busy), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule